// File: doc/BRIEF.md
# VMEbus Slave Window Decoder

This block sits behind the VMEbus receivers of a board that answers in a single 1 MB window. It looks at the address lines, the address-modifier code, the address strobe, both data strobes and LWORD. It compares them against a set of jumper-style configuration inputs that hold the base address and the accepted modifier codes. When an access belongs to the board, it raises a board-select, one of twelve one-hot region selects for the local memories and peripherals, and, after a guaranteed minimum delay, the data-transfer acknowledge.

The modifier matching is partial and strap-driven. AM0 and AM1 are fixed. AM4 and AM5 must agree with each other and with a strap, and that agreement also picks the addressing width: short 24-bit or extended 32-bit. AM3 follows its own strap, so codes the bus standard reserves can still be accepted. AM2 can be required low, required high, or ignored. Every strap reads 0 when its jumper is fitted, and the strap value is the level that is compared. Only 16-bit data cycles are served.

The decoded selects are registered when a qualified access is first seen and are held for the whole bus cycle. The acknowledge comes from a cycle counter whose length is the minimum delay divided by the clock period, rounded up.

Top module: `vme_slave_decode`

## Requirements
- R1: An access is accepted only when AM0 = 1 and AM1 = 0; any other combination of these two bits gives no select and no acknowledge.
- R2: AM4 and AM5 must be equal and equal to `strap_am45_n`. Both high selects 24-bit addressing and both low selects 32-bit addressing. Codes with AM4 ≠ AM5 are never accepted.
- R3: `strap_am2_n` controls AM2. Bit 1 = 1 ignores AM2. Bit 1 = 0 requires AM2 to equal bit 0. With the default straps (AM3 strap 1, AM2 ignored) the short codes 3D and 39 hex are both accepted.
- R4: AM3 must equal `strap_am3_n`. With that strap at 0 the board answers reserved codes such as 35 hex, and it no longer answers 3D hex.
- R5: In 24-bit mode, only A23..A20 are compared, against `strap_base_lo_n`, and `strap_base_hi_n` and A31..A24 are ignored. In 32-bit mode, A31..A20 are compared against {`strap_base_hi_n`, `strap_base_lo_n`}.
- R6: Window offset A19..A1 selects one bit of `region_sel`. Bit 0 is the RAM (000000–07FFFF). Bit 2 is the watchdog trigger (0A0000–0AFFFF). Bit 1 is the ROM (0C0000–0FFFFF).
- R7: Offsets 080000–087FFF are peripheral slots chosen by A14..A12. Slots 0..6 drive `region_sel` bits 3..9. Slot 7 drives bit 10 (forced reset) when A10 = 0 and bit 11 (forced abort) when A10 = 1.
- R8: Offsets outside every region (088000–09FFFF and 0B0000–0BFFFF) give no board-select, no region select and no acknowledge.
- R9: `board_sel` and the region select rise on the first clock edge at which a qualified matching access is sampled. `vme_dtack_n` falls exactly ceil(DTACK_MIN_PS / CLK_PERIOD_PS) edges later: 18 edges at the default 8 ns clock and 140 ns minimum.
- R10: When AS is sampled negated, or both data strobes are sampled negated, `board_sel`, `region_sel` and the acknowledge are all cleared on that same edge.
- R11: An access with `vme_lword_n` = 0 (a 32-bit transfer) gets no select and no acknowledge.
- R12: An access is qualified only while AS and at least one data strobe are low. Once the access is taken, `region_sel` holds its value even if the address changes during the cycle.
- R13: While `rst` is high and after it, with no access, `board_sel` = 0, `region_sel` = 0 and `vme_dtack_n` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous reset, active high |
| vme_addr | input | 31 | Address lines A31..A1 |
| vme_am | input | 6 | Address-modifier code AM5..AM0 |
| vme_as_n | input | 1 | Address strobe, active low |
| vme_ds0_n | input | 1 | Data strobe 0, active low |
| vme_ds1_n | input | 1 | Data strobe 1, active low |
| vme_lword_n | input | 1 | Long-word indicator, active low |
| strap_base_lo_n | input | 4 | Base address A23..A20 (fitted jumper = 0) |
| strap_base_hi_n | input | 8 | Base address A31..A24, used in 32-bit mode |
| strap_am45_n | input | 1 | Required level of AM4 and AM5 |
| strap_am3_n | input | 1 | Required level of AM3 |
| strap_am2_n | input | 2 | Bit 1: ignore AM2; bit 0: required AM2 level |
| board_sel | output | 1 | Access belongs to this board |
| region_sel | output | 12 | One-hot local region select |
| vme_dtack_n | output | 1 | Data-transfer acknowledge, active low |

## Verification
The selects are due one rising edge after the edge that first samples a qualified access. The acknowledge is due 18 edges after that at the default parameters, and the release is due on the edge that samples the negated strobe. The bench changes inputs only on falling edges and reads outputs on the next falling edge, so each check is half a cycle after the edge it targets. It reads the acknowledge both one edge before and on its due edge, so an early or late acknowledge is caught. Rejected accesses are held for longer than the acknowledge delay before the bench confirms that nothing answered.

// File: rtl/vsd_pkg.sv
package vsd_pkg;

    localparam int WIN_BITS    = 20;   // 1 MB window
    localparam int LO_BASE_W   = 4;    // A23..A20
    localparam int HI_BASE_W   = 8;    // A31..A24
    localparam int NUM_SLOTS   = 8;
    localparam int NUM_REGIONS = 3 + NUM_SLOTS + 1;

    localparam int RG_RAM    = 0;
    localparam int RG_ROM    = 1;
    localparam int RG_WDOG   = 2;
    localparam int RG_SLOT0  = 3;
    localparam int RG_FRESET = RG_SLOT0 + NUM_SLOTS - 1;
    localparam int RG_FABORT = RG_FRESET + 1;

    typedef logic [NUM_REGIONS-1:0] region_vec_t;

    typedef enum logic {
        MODE_SHORT = 1'b0,
        MODE_EXT   = 1'b1
    } addr_mode_e;

    typedef struct packed {
        logic am_ok;
        logic base_ok;
        logic width_ok;
    } match_t;

    function automatic logic am2_accept(input logic [1:0] strap, input logic am2);
        return strap[1] | (am2 == strap[0]);
    endfunction

endpackage

// File: rtl/vsd_match.sv
module vsd_match
    import vsd_pkg::*;
(
    input  logic [31:WIN_BITS]     addr_hi,
    input  logic [5:0]             am,
    input  logic                   lword_n,
    input  logic [LO_BASE_W-1:0]   base_lo,
    input  logic [HI_BASE_W-1:0]   base_hi,
    input  logic                   am45_lvl,
    input  logic                   am3_lvl,
    input  logic [1:0]             am2_cfg,
    output match_t                 result,
    output addr_mode_e             mode
);

    localparam int LO_TOP = WIN_BITS + LO_BASE_W - 1;

    always_comb begin
        mode = (am[5] & am[4]) ? MODE_SHORT : MODE_EXT;

        result.am_ok = am[0] & ~am[1]
                     & (am[4] == am[5])
                     & (am[4] == am45_lvl)
                     & (am[3] == am3_lvl)
                     & am2_accept(am2_cfg, am[2]);

        if (mode == MODE_SHORT)
            result.base_ok = (addr_hi[LO_TOP:WIN_BITS] == base_lo);
        else
            result.base_ok = (addr_hi == {base_hi, base_lo});

        result.width_ok = lword_n;
    end

endmodule

// File: rtl/vsd_region.sv
module vsd_region
    import vsd_pkg::*;
(
    input  logic [WIN_BITS-1:1] offset,
    output region_vec_t         sel
);

    logic [2:0]           slot;
    logic                 periph;
    logic [NUM_SLOTS-1:0] slot_hit;

    assign slot   = offset[14:12];
    assign periph = (offset[19:15] == 5'b10000);

    generate
        for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
            assign slot_hit[s] = periph && (slot == 3'(s));
        end
    endgenerate

    always_comb begin
        sel = '0;
        sel[RG_RAM]  = ~offset[19];
        sel[RG_ROM]  = (offset[19:18] == 2'b11);
        sel[RG_WDOG] = (offset[19:16] == 4'hA);
        for (int s = 0; s < NUM_SLOTS - 1; s++)
            sel[RG_SLOT0 + s] = slot_hit[s];
        sel[RG_FRESET] = slot_hit[NUM_SLOTS-1] & ~offset[10];
        sel[RG_FABORT] = slot_hit[NUM_SLOTS-1] &  offset[10];
    end

endmodule

// File: rtl/vsd_dtack_timer.sv
module vsd_dtack_timer #(
    parameter int CYCLES = 18
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic clear,
    output logic done
);

    localparam int CNT_W = $clog2(CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES);

    logic [CNT_W-1:0] cnt;
    logic             running;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (start) begin
            cnt     <= '0;
            running <= 1'b1;
        end else if (running && cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = running && (cnt == LAST);

endmodule

// File: rtl/vme_slave_decode.sv
module vme_slave_decode
    import vsd_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 8000,
    parameter int DTACK_MIN_PS  = 140000
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [31:1]           vme_addr,
    input  logic [5:0]            vme_am,
    input  logic                  vme_as_n,
    input  logic                  vme_ds0_n,
    input  logic                  vme_ds1_n,
    input  logic                  vme_lword_n,
    input  logic [LO_BASE_W-1:0]  strap_base_lo_n,
    input  logic [HI_BASE_W-1:0]  strap_base_hi_n,
    input  logic                  strap_am45_n,
    input  logic                  strap_am3_n,
    input  logic [1:0]            strap_am2_n,
    output logic                  board_sel,
    output logic [NUM_REGIONS-1:0] region_sel,
    output logic                  vme_dtack_n
);

    localparam int DTACK_CYC = (DTACK_MIN_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;

    match_t      m;
    addr_mode_e  mode;
    region_vec_t region_c;
    region_vec_t region_q;
    logic        active;
    logic        strobe_on, strobe_off, hit, start, clear, ack;

    vsd_match u_match (
        .addr_hi  (vme_addr[31:WIN_BITS]),
        .am       (vme_am),
        .lword_n  (vme_lword_n),
        .base_lo  (strap_base_lo_n),
        .base_hi  (strap_base_hi_n),
        .am45_lvl (strap_am45_n),
        .am3_lvl  (strap_am3_n),
        .am2_cfg  (strap_am2_n),
        .result   (m),
        .mode     (mode)
    );

    vsd_region u_region (
        .offset (vme_addr[WIN_BITS-1:1]),
        .sel    (region_c)
    );

    assign strobe_on  = ~vme_as_n & ~(vme_ds0_n & vme_ds1_n);
    assign strobe_off = vme_as_n | (vme_ds0_n & vme_ds1_n);
    assign hit        = m.am_ok & m.base_ok & m.width_ok & (|region_c);
    assign start      = ~active & strobe_on & hit;
    assign clear      = active & strobe_off;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            active   <= 1'b0;
            region_q <= '0;
        end else if (start) begin
            active   <= 1'b1;
            region_q <= region_c;
        end
    end

    vsd_dtack_timer #(.CYCLES(DTACK_CYC)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .clear (clear),
        .done  (ack)
    );

    assign board_sel   = active;
    assign region_sel  = region_q;
    assign vme_dtack_n = ~ack;

endmodule

// File: rtl/vsd_checker.sv
module vsd_checker #(
    parameter int DTACK_CYC = 18,
    parameter int NREG      = 12
) (
    input logic            clk,
    input logic            rst,
    input logic            vme_as_n,
    input logic            vme_lword_n,
    input logic            board_sel,
    input logic [NREG-1:0] region_sel,
    input logic            vme_dtack_n
);

    localparam int HW = $clog2(DTACK_CYC + 2);
    logic [HW-1:0] held;

    always_ff @(posedge clk) begin
        if (rst || !board_sel)
            held <= '0;
        else if (held != HW'(DTACK_CYC + 1))
            held <= held + 1'b1;
    end

    AST_REGION_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(region_sel)); // R6

    AST_REGION_NEEDS_BOARD: assert property (@(posedge clk) disable iff (rst)
        (region_sel != '0) == board_sel); // R8

    AST_DTACK_MIN_DELAY: assert property (@(posedge clk) disable iff (rst)
        !vme_dtack_n |-> (board_sel && held >= HW'(DTACK_CYC))); // R9

    AST_RELEASE_ON_AS: assert property (@(posedge clk) disable iff (rst)
        (board_sel && vme_as_n) |=> (!board_sel && vme_dtack_n && region_sel == '0)); // R10

    AST_NO_LONG_WORD: assert property (@(posedge clk) disable iff (rst)
        $rose(board_sel) |-> $past(vme_lword_n)); // R11

    AST_SELECT_HELD: assert property (@(posedge clk) disable iff (rst)
        (board_sel && $past(board_sel)) |-> $stable(region_sel)); // R12

endmodule

bind vme_slave_decode vsd_checker #(
    .DTACK_CYC (DTACK_CYC),
    .NREG      (vsd_pkg::NUM_REGIONS)
) u_vsd_checker (
    .clk         (clk),
    .rst         (rst),
    .vme_as_n    (vme_as_n),
    .vme_lword_n (vme_lword_n),
    .board_sel   (board_sel),
    .region_sel  (region_sel),
    .vme_dtack_n (vme_dtack_n)
);

// File: tb/vme_slave_decode_test.sv
`timescale 1ns/1ps
module vme_slave_decode_test;

    localparam int EXP_DTACK = 18;   // 140 ns / 8 ns = 17.5, rounded up
    localparam int MAX_CYC   = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] addr = '0;
    logic [5:0]  am = 6'h3D;
    logic        as_n = 1'b1, ds0_n = 1'b1, ds1_n = 1'b1, lword_n = 1'b1;
    logic [3:0]  s_lo = 4'h8;
    logic [7:0]  s_hi = 8'h00;
    logic        s_am45 = 1'b1, s_am3 = 1'b1;
    logic [1:0]  s_am2 = 2'b10;
    logic        board_sel, dtack_n;
    logic [11:0] region;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    vme_slave_decode uut (
        .clk             (clk),
        .rst             (rst),
        .vme_addr        (addr[31:1]),
        .vme_am          (am),
        .vme_as_n        (as_n),
        .vme_ds0_n       (ds0_n),
        .vme_ds1_n       (ds1_n),
        .vme_lword_n     (lword_n),
        .strap_base_lo_n (s_lo),
        .strap_base_hi_n (s_hi),
        .strap_am45_n    (s_am45),
        .strap_am3_n     (s_am3),
        .strap_am2_n     (s_am2),
        .board_sel       (board_sel),
        .region_sel      (region),
        .vme_dtack_n     (dtack_n)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic set_straps(input logic [3:0] lo, input logic [7:0] hi, input logic a45,
                              input logic a3, input logic [1:0] a2);
        @(negedge clk);
        s_lo = lo; s_hi = hi; s_am45 = a45; s_am3 = a3; s_am2 = a2;
    endtask

    // One complete bus cycle; exp = expected region bits (0 = no response)
    task automatic run_access(input logic [31:0] a, input logic [5:0] code, input logic lw,
                              input logic [11:0] exp, input string req);
        @(negedge clk);
        addr = a; am = code; lword_n = lw;
        as_n = 1'b0; ds0_n = 1'b0; ds1_n = 1'b0;
        @(negedge clk);
        chk(region == exp, req, 32'(region), 32'(exp));
        chk(board_sel == (exp != '0), req, 32'(board_sel), 32'(exp != '0));
        if (exp != '0) begin
            repeat (EXP_DTACK - 1) @(negedge clk);
            chk(dtack_n == 1'b1, {req, " R9 early"}, 32'(dtack_n), 32'd1);
            @(negedge clk);
            chk(dtack_n == 1'b0, {req, " R9 due"}, 32'(dtack_n), 32'd0);
        end else begin
            repeat (EXP_DTACK + 2) @(negedge clk);
            chk(dtack_n == 1'b1 && board_sel == 1'b0, {req, " no-ack"},
                {dtack_n, board_sel}, 32'h2);
        end
        as_n = 1'b1; ds0_n = 1'b1; ds1_n = 1'b1;
        @(negedge clk);
        chk(board_sel == 1'b0 && region == '0 && dtack_n == 1'b1, "R10 release",
            {region, board_sel, dtack_n}, 32'h1);
        lword_n = 1'b1;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk(board_sel == 1'b0 && region == '0 && dtack_n == 1'b1, "R13 in reset",
            {region, board_sel, dtack_n}, 32'h1);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(board_sel == 1'b0 && region == '0 && dtack_n == 1'b1, "R13 after reset",
            {region, board_sel, dtack_n}, 32'h1);
    endtask

    task automatic t_am_basic;
        set_straps(4'h8, 8'h00, 1'b1, 1'b1, 2'b10);
        run_access(32'h0081_2340, 6'h3D, 1'b1, 12'h001, "R3 code 3D");
        run_access(32'h0081_2340, 6'h39, 1'b1, 12'h001, "R3 code 39");
        run_access(32'h0081_2340, 6'h3C, 1'b1, 12'h000, "R1 AM0 low");
        run_access(32'h0081_2340, 6'h3F, 1'b1, 12'h000, "R1 AM1 high");
        run_access(32'h0081_2340, 6'h2D, 1'b1, 12'h000, "R2 AM4 ne AM5");
    endtask

    task automatic t_am2;
        set_straps(4'h8, 8'h00, 1'b1, 1'b1, 2'b00);
        run_access(32'h0080_0000, 6'h3D, 1'b1, 12'h000, "R3 AM2 must be 0, got 1");
        run_access(32'h0080_0000, 6'h39, 1'b1, 12'h001, "R3 AM2 must be 0");
        set_straps(4'h8, 8'h00, 1'b1, 1'b1, 2'b01);
        run_access(32'h0080_0000, 6'h39, 1'b1, 12'h000, "R3 AM2 must be 1, got 0");
        run_access(32'h0080_0000, 6'h3D, 1'b1, 12'h001, "R3 AM2 must be 1");
    endtask

    task automatic t_am3;
        set_straps(4'h8, 8'h00, 1'b1, 1'b0, 2'b10);
        run_access(32'h0080_0000, 6'h35, 1'b1, 12'h001, "R4 reserved 35");
        run_access(32'h0080_0000, 6'h3D, 1'b1, 12'h000, "R4 AM3 mismatch");
    endtask

    task automatic t_base;
        set_straps(4'h8, 8'h5A, 1'b1, 1'b1, 2'b10);
        run_access(32'hFF80_0000, 6'h3D, 1'b1, 12'h001, "R5 short ignores high base");
        run_access(32'h0090_0000, 6'h3D, 1'b1, 12'h000, "R5 short base miss");
        run_access(32'h5A80_0000, 6'h0D, 1'b1, 12'h000, "R2 extended code with short strap");
        set_straps(4'h3, 8'h12, 1'b0, 1'b1, 2'b10);
        run_access(32'h1230_0000, 6'h0D, 1'b1, 12'h001, "R5 extended 0D");
        run_access(32'h1230_0000, 6'h09, 1'b1, 12'h001, "R5 extended 09");
        run_access(32'h1330_0000, 6'h0D, 1'b1, 12'h000, "R5 extended high miss");
        run_access(32'h1230_0000, 6'h3D, 1'b1, 12'h000, "R2 short code with extended strap");
    endtask

    task automatic t_regions;
        set_straps(4'h8, 8'h00, 1'b1, 1'b1, 2'b10);
        run_access(32'h0087_FFFE, 6'h3D, 1'b1, 12'h001, "R6 RAM top");
        run_access(32'h008C_0000, 6'h3D, 1'b1, 12'h002, "R6 ROM base");
        run_access(32'h008F_FFFE, 6'h3D, 1'b1, 12'h002, "R6 ROM top");
        run_access(32'h008A_0000, 6'h3D, 1'b1, 12'h004, "R6 watchdog");
        run_access(32'h0088_0000, 6'h3D, 1'b1, 12'h008, "R7 slot 0");
        run_access(32'h0088_3000, 6'h3D, 1'b1, 12'h040, "R7 slot 3");
        run_access(32'h0088_6FFE, 6'h3D, 1'b1, 12'h200, "R7 slot 6");
        run_access(32'h0088_7000, 6'h3D, 1'b1, 12'h400, "R7 forced reset");
        run_access(32'h0088_7400, 6'h3D, 1'b1, 12'h800, "R7 forced abort");
        run_access(32'h0088_8000, 6'h3D, 1'b1, 12'h000, "R8 hole 088000");
        run_access(32'h008B_0000, 6'h3D, 1'b1, 12'h000, "R8 hole 0B0000");
    endtask

    task automatic t_lword;
        run_access(32'h0080_0000, 6'h3D, 1'b0, 12'h000, "R11 LWORD low");
    endtask

    task automatic t_qualify_hold;
        @(negedge clk);
        addr = 32'h0080_1000; am = 6'h3D; as_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(board_sel == 1'b0, "R12 AS without DS", 32'(board_sel), 32'd0);
        ds1_n = 1'b0;
        @(negedge clk);
        chk(region == 12'h001, "R12 DS1 qualifies", 32'(region), 32'h001);
        addr = 32'h008C_0000;
        repeat (2) @(negedge clk);
        chk(region == 12'h001, "R12 select held", 32'(region), 32'h001);
        as_n = 1'b1;
        @(negedge clk);
        chk(board_sel == 1'b0 && region == '0 && dtack_n == 1'b1, "R10 AS negated",
            {region, board_sel, dtack_n}, 32'h1);
        ds1_n = 1'b1;
        @(negedge clk);
        ds0_n = 1'b0; as_n = 1'b0; addr = 32'h0080_0000;
        @(negedge clk);
        chk(board_sel == 1'b1, "R12 DS0 qualifies", 32'(board_sel), 32'd1);
        ds0_n = 1'b1;
        @(negedge clk);
        chk(board_sel == 1'b0 && region == '0, "R10 strobes negated",
            {region, board_sel}, 32'h0);
        as_n = 1'b1;
    endtask

    initial begin
        t_reset();
        t_am_basic();
        t_am2();
        t_am3();
        t_base();
        t_regions();
        t_lword();
        t_qualify_hold();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (MAX_CYC) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule